// File: doc/BRIEF.md
# Triggered Event Snapshot Readout Buffer

This block keeps a rolling record of a trigger board's per-tick activity: a 153-bit segment mask, a wide vector of fit results from the processing engines, and an 8-bit decision. On every tick strobe it writes these into a short circular history. When a level-one accept arrives, it freezes the eight most recent ticks into one of four event buffers, chosen by a 2-bit select, and tags the event with a running count.

A host drains each frozen event as a fixed 282-word sequence of 16-bit words. It first names a buffer with a read-start pulse and then issues one strobe per word. The sequence opens with a tag word and a status word. Next come ten mask words per tick, oldest tick first. Last come twenty-five result words per tick. When the final word has gone out, the buffer is free to receive a new event. An accept aimed at a buffer that still holds unread data is refused, and the refusal is latched in a sticky overflow flag.

Top module: `snap_readout_buf`

## Requirements
- R1: After reset, rd_valid and rd_last are low, all four buffers are free, the event count is zero and the overflow flag is clear.
- R2: Each cycle with tick_en high stores that cycle's inputs in the history. An accept captures the eight ticks stored before the accept cycle, oldest first. Slots never written since reset read back as zero.
- R3: An accept to a free buffer marks it occupied and increments the event count. It stores tag word {buffer index in bits 15:14, low 14 bits of the count including this event}.
- R4: An accept to an occupied buffer sets a sticky overflow flag and leaves the buffer contents, its tag and the event count unchanged.
- R5: A read start names a buffer. If that buffer is occupied and no readout is in progress, a readout session opens. Otherwise the read start is ignored, and later strobes produce no words.
- R6: During a session, each strobe yields exactly one word with rd_valid high on the following cycle. A cycle without a strobe gives rd_valid low.
- R7: Word 1 is the tag. Word 2 is the status word: bit 15 is overflow, bits 3:0 are the occupied flags of buffers 3..0, and all other bits are zero.
- R8: Words 3 to 82 are the mask section, ten words per tick, ticks oldest first. Word k of a tick holds mask bits 16k+15:16k, LSB first. The tenth word holds bits 152:144 in bits 8:0, with its upper bits zero.
- R9: Words 83 to 282 are the result section, twenty-five words per tick, ticks oldest first. Words 0 to 23 of a tick hold the 384-bit fit vector LSB first. Word 24 holds the decision in bits 7:0, with its upper bits zero.
- R10: rd_last is high with word 282 only. After it the session closes and the buffer is free, so a following accept fills it without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Store this cycle's inputs in the history |
| seg_mask | input | 153 | Segment mask of the current tick |
| fit_res | input | 384 | Concatenated fit results of the current tick |
| decision | input | 8 | Trigger decision of the current tick |
| l1a | input | 1 | Level-one accept strobe |
| l1a_sel | input | 2 | Target buffer of the accept |
| rd_start | input | 1 | Open a readout session |
| rd_sel | input | 2 | Buffer to read |
| rd_strobe | input | 1 | Request the next word |
| rd_data | output | 16 | Readout word |
| rd_valid | output | 1 | rd_data holds a word this cycle |
| rd_last | output | 1 | This word is the final one of the record |

## Verification
Assertions check, on every cycle, the local rules that hold at any instant. The history pointer advances only on ticks. The overflow flag never clears. A refused accept leaves the tags and the count untouched, while an accepted one raises the occupied flag and adds one to the count. Valid words appear only one cycle after a strobe, rd_last comes only with a valid word, and freeing a buffer coincides with the last word. Only the bench scenarios can show the things that span many cycles. These are the exact content and order of all 282 words against an independent model, zero fill after a short history, the frozen contents after a refused accept, reuse of a drained buffer, and silence after a read start on a free buffer.

// File: rtl/snap_pkg.sv
package snap_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        SEC_HDR = 2'd0,
        SEC_INP = 2'd1,
        SEC_RES = 2'd2
    } sec_e;
endpackage

// File: rtl/snap_history.sv
module snap_history #(
    parameter int REC_W = 545,
    parameter int WIN   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [REC_W-1:0]               wr_rec,
    output logic [WIN-1:0][REC_W-1:0]      win_o
);
    localparam int PTR_W = (WIN > 1) ? $clog2(WIN) : 1;

    typedef struct packed {
        logic [WIN-1:0][REC_W-1:0] ring;
        logic [PTR_W-1:0]          wp;
    } hist_t;

    hist_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.ring[s_q.wp] = wr_rec;
            s_d.wp = (int'(s_q.wp) == WIN - 1) ? '0 : s_q.wp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // oldest slot sits at the write pointer
    always_comb begin
        for (int k = 0; k < WIN; k++) begin
            win_o[k] = s_q.ring[PTR_W'((int'(s_q.wp) + k) % WIN)];
        end
    end

    // R2: pointer moves one slot per tick, wrapping at WIN
    a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (s_q.wp == ((int'($past(s_q.wp)) == WIN - 1) ? PTR_W'(0) : PTR_W'($past(s_q.wp) + 1'b1))));

    // R2: no tick, no movement
    a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.wp));
endmodule

// File: rtl/snap_store.sv
module snap_store #(
    parameter int REC_W = 545,
    parameter int WIN   = 8,
    parameter int NBUF  = 4,
    parameter int CNT_W = 16,
    parameter int WORD_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_i,
    input  logic [$clog2(NBUF)-1:0]           acc_sel,
    input  logic [WIN-1:0][REC_W-1:0]         win_i,
    input  logic                              rel_i,
    input  logic [$clog2(NBUF)-1:0]           rel_sel,
    input  logic [$clog2(NBUF)-1:0]           rd_buf,
    input  logic [$clog2(WIN)-1:0]            rd_tk,
    output logic [REC_W-1:0]                  rd_rec_o,
    output logic [WORD_W-1:0]                 rd_tag_o,
    output logic [NBUF-1:0]                   full_o,
    output logic                              ovf_o
);
    localparam int BUF_AW = $clog2(NBUF);
    localparam int TAG_CW = WORD_W - BUF_AW;

    typedef struct packed {
        logic [NBUF-1:0][WIN-1:0][REC_W-1:0] mem;
        logic [NBUF-1:0][WORD_W-1:0]         tag;
        logic [NBUF-1:0]                     full;
        logic                                ovf;
        logic [CNT_W-1:0]                    ctr;
    } store_t;

    store_t s_d, s_q;
    logic [CNT_W-1:0] ctr_inc;

    always_comb begin
        s_d = s_q;
        ctr_inc = s_q.ctr + 1'b1;
        if (rel_i) s_d.full[rel_sel] = 1'b0;
        if (acc_i) begin
            if (s_q.full[acc_sel]) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.mem[acc_sel]  = win_i;
                s_d.tag[acc_sel]  = {acc_sel, ctr_inc[TAG_CW-1:0]};
                s_d.full[acc_sel] = 1'b1;
                s_d.ctr           = ctr_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_rec_o = s_q.mem[rd_buf][rd_tk];
    assign rd_tag_o = s_q.tag[rd_buf];
    assign full_o   = s_q.full;
    assign ovf_o    = s_q.ovf;

    // R4: overflow is sticky
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf |=> s_q.ovf);

    // R4: refused accept keeps tags and count
    a_r4_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && s_q.full[acc_sel]) |=> ($stable(s_q.tag) && $stable(s_q.ctr) && s_q.ovf));

    // R3: accepted event counts once and occupies its buffer
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !s_q.full[acc_sel]) |=> (s_q.ctr == $past(s_q.ctr) + 1'b1) && s_q.full[$past(acc_sel)]);

    // R3: count moves only on an accept
    a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_i |=> $stable(s_q.ctr));
endmodule

// File: rtl/snap_reader.sv
module snap_reader
    import snap_pkg::*;
#(
    parameter int MASK_W = 153,
    parameter int FIT_W  = 384,
    parameter int DEC_W  = 8,
    parameter int WIN    = 8,
    parameter int NBUF   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [$clog2(NBUF)-1:0]           start_sel,
    input  logic                              strobe_i,
    input  logic [NBUF-1:0]                   full_i,
    input  logic                              ovf_i,
    input  logic [MASK_W+FIT_W+DEC_W-1:0]     rec_i,
    input  logic [WORD_W-1:0]                 tag_i,
    output logic [$clog2(NBUF)-1:0]           look_buf,
    output logic [$clog2(WIN)-1:0]            look_tk,
    output logic                              rel_o,
    output logic [$clog2(NBUF)-1:0]           rel_sel,
    output logic [WORD_W-1:0]                 data_o,
    output logic                              valid_o,
    output logic                              last_o
);
    localparam int MASK_WORDS = (MASK_W + WORD_W - 1) / WORD_W;
    localparam int FIT_WORDS  = (FIT_W + WORD_W - 1) / WORD_W;
    localparam int RES_WORDS  = FIT_WORDS + 1;
    localparam int BUF_AW     = $clog2(NBUF);
    localparam int TK_W       = $clog2(WIN);
    localparam int WD_W       = $clog2(RES_WORDS + 1);

    typedef struct packed {
        logic              active;
        logic [BUF_AW-1:0] bsel;
        sec_e              sec;
        logic [TK_W-1:0]   tk;
        logic [WD_W-1:0]   wd;
        logic [WORD_W-1:0] data;
        logic              valid;
        logic              last;
    } rd_t;

    rd_t s_d, s_q;

    logic [MASK_WORDS*WORD_W-1:0] mpad;
    logic [FIT_WORDS*WORD_W-1:0]  fpad;
    logic [WORD_W-1:0]            word;
    logic [WORD_W-1:0]            status;
    logic                         rec_end;
    logic                         tk_end;
    int                           widx;

    always_comb begin
        s_d      = s_q;
        s_d.valid = 1'b0;
        s_d.last  = 1'b0;
        rel_o    = 1'b0;

        mpad = '0;
        mpad[MASK_W-1:0] = rec_i[MASK_W-1:0];
        fpad = '0;
        fpad[FIT_W-1:0] = rec_i[MASK_W +: FIT_W];

        status = '0;
        status[WORD_W-1] = ovf_i;
        status[NBUF-1:0] = full_i;

        widx = int'(s_q.wd);
        word = '0;
        unique case (s_q.sec)
            SEC_HDR: word = (widx == 0) ? tag_i : status;
            SEC_INP: word = mpad[widx*WORD_W +: WORD_W];
            SEC_RES: begin
                if (widx < FIT_WORDS) word = fpad[widx*WORD_W +: WORD_W];
                else                  word[DEC_W-1:0] = rec_i[MASK_W+FIT_W +: DEC_W];
            end
            default: word = '0;
        endcase

        tk_end  = (int'(s_q.tk) == WIN - 1);
        rec_end = (s_q.sec == SEC_RES) && (widx == RES_WORDS - 1) && tk_end;

        if (s_q.active) begin
            if (strobe_i) begin
                s_d.data  = word;
                s_d.valid = 1'b1;
                s_d.last  = rec_end;
                rel_o     = rec_end;
                unique case (s_q.sec)
                    SEC_HDR: begin
                        if (widx == 1) begin
                            s_d.sec = SEC_INP;
                            s_d.wd  = '0;
                            s_d.tk  = '0;
                        end else begin
                            s_d.wd = s_q.wd + 1'b1;
                        end
                    end
                    SEC_INP: begin
                        if (widx == MASK_WORDS - 1) begin
                            s_d.wd = '0;
                            if (tk_end) begin
                                s_d.sec = SEC_RES;
                                s_d.tk  = '0;
                            end else begin
                                s_d.tk = s_q.tk + 1'b1;
                            end
                        end else begin
                            s_d.wd = s_q.wd + 1'b1;
                        end
                    end
                    SEC_RES: begin
                        if (widx == RES_WORDS - 1) begin
                            s_d.wd = '0;
                            if (tk_end) begin
                                s_d.active = 1'b0;
                                s_d.sec    = SEC_HDR;
                                s_d.tk     = '0;
                            end else begin
                                s_d.tk = s_q.tk + 1'b1;
                            end
                        end else begin
                            s_d.wd = s_q.wd + 1'b1;
                        end
                    end
                    default: s_d.active = 1'b0;
                endcase
            end
        end else if (start_i && full_i[start_sel]) begin
            s_d.active = 1'b1;
            s_d.bsel   = start_sel;
            s_d.sec    = SEC_HDR;
            s_d.tk     = '0;
            s_d.wd     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.sec <= SEC_HDR;
        end else begin
            s_q <= s_d;
        end
    end

    assign look_buf = s_q.bsel;
    assign look_tk  = s_q.tk;
    assign rel_sel  = s_q.bsel;
    assign data_o   = s_q.data;
    assign valid_o  = s_q.valid;
    assign last_o   = s_q.last;

    // R6: a word only follows a strobe
    a_r6_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(strobe_i));

    // R10: last flag only on a delivered word
    a_r10_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R10: buffer release coincides with the final word
    a_r10_release_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        rel_o |=> (last_o && !s_q.active));

    // R5: a session only opens on an occupied buffer
    a_r5_open_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.active) |-> $past(full_i[start_sel] && start_i));
endmodule

// File: rtl/snap_readout_buf.sv
module snap_readout_buf
    import snap_pkg::*;
#(
    parameter int MASK_W = 153,
    parameter int FIT_W  = 384,
    parameter int DEC_W  = 8,
    parameter int WIN    = 8,
    parameter int NBUF   = 4,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_en,
    input  logic [MASK_W-1:0]        seg_mask,
    input  logic [FIT_W-1:0]         fit_res,
    input  logic [DEC_W-1:0]         decision,
    input  logic                     l1a,
    input  logic [$clog2(NBUF)-1:0]  l1a_sel,
    input  logic                     rd_start,
    input  logic [$clog2(NBUF)-1:0]  rd_sel,
    input  logic                     rd_strobe,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     rd_valid,
    output logic                     rd_last
);
    localparam int REC_W  = MASK_W + FIT_W + DEC_W;
    localparam int BUF_AW = $clog2(NBUF);
    localparam int TK_W   = $clog2(WIN);

    logic [WIN-1:0][REC_W-1:0] win;
    logic [REC_W-1:0]          rec;
    logic [WORD_W-1:0]         tag;
    logic [NBUF-1:0]           full;
    logic                      ovf;
    logic [BUF_AW-1:0]         look_buf;
    logic [TK_W-1:0]           look_tk;
    logic                      rel;
    logic [BUF_AW-1:0]         rel_sel;

    snap_history #(.REC_W(REC_W), .WIN(WIN)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tick_en),
        .wr_rec ({decision, fit_res, seg_mask}),
        .win_o  (win)
    );

    snap_store #(
        .REC_W(REC_W), .WIN(WIN), .NBUF(NBUF), .CNT_W(CNT_W), .WORD_W(WORD_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_i    (l1a),
        .acc_sel  (l1a_sel),
        .win_i    (win),
        .rel_i    (rel),
        .rel_sel  (rel_sel),
        .rd_buf   (look_buf),
        .rd_tk    (look_tk),
        .rd_rec_o (rec),
        .rd_tag_o (tag),
        .full_o   (full),
        .ovf_o    (ovf)
    );

    snap_reader #(
        .MASK_W(MASK_W), .FIT_W(FIT_W), .DEC_W(DEC_W), .WIN(WIN), .NBUF(NBUF)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (rd_start),
        .start_sel (rd_sel),
        .strobe_i  (rd_strobe),
        .full_i    (full),
        .ovf_i     (ovf),
        .rec_i     (rec),
        .tag_i     (tag),
        .look_buf  (look_buf),
        .look_tk   (look_tk),
        .rel_o     (rel),
        .rel_sel   (rel_sel),
        .data_o    (rd_data),
        .valid_o   (rd_valid),
        .last_o    (rd_last)
    );

    // R1: outputs quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rd_valid && !rd_last));
endmodule

// File: tb/sim_snap_readout_buf.sv
module sim_snap_readout_buf;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic [152:0] seg_mask = '0;
    logic [383:0] fit_res = '0;
    logic [7:0]   decision = '0;
    logic         l1a = 1'b0;
    logic [1:0]   l1a_sel = '0;
    logic         rd_start = 1'b0;
    logic [1:0]   rd_sel = '0;
    logic         rd_strobe = 1'b0;
    logic [15:0]  rd_data;
    logic         rd_valid;
    logic         rd_last;

    always #5 clk = ~clk;

    snap_readout_buf u0 (.*);

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model
    logic [152:0] h_mask [8];
    logic [383:0] h_fit  [8];
    logic [7:0]   h_dec  [8];
    int           h_wp = 0;
    logic [152:0] b_mask [4][8];
    logic [383:0] b_fit  [4][8];
    logic [7:0]   b_dec  [4][8];
    logic [15:0]  b_tag  [4];
    bit           b_full [4];
    bit           m_ovf = 1'b0;
    int           m_cnt = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_word(input int b, input int i);
        logic [159:0] mp;
        int j, t, w;
        logic [15:0] st;
        if (i == 0) return b_tag[b];
        if (i == 1) begin
            st = '0;
            st[15] = m_ovf;
            for (int k = 0; k < 4; k++) st[k] = b_full[k];
            return st;
        end
        if (i < 82) begin
            j = i - 2; t = j / 10; w = j % 10;
            mp = {7'b0, b_mask[b][t]};
            return mp[w*16 +: 16];
        end
        j = i - 82; t = j / 25; w = j % 25;
        if (w < 24) return b_fit[b][t][w*16 +: 16];
        return {8'b0, b_dec[b][t]};
    endfunction

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            for (int q = 0; q < 5; q++) seg_mask[q*32 +: 32] = $urandom();
            for (int q = 0; q < 12; q++) fit_res[q*32 +: 32] = $urandom();
            decision = 8'($urandom());
            tick_en = 1'b1;
            @(negedge clk);
            h_mask[h_wp] = seg_mask; h_fit[h_wp] = fit_res; h_dec[h_wp] = decision;
            h_wp = (h_wp + 1) % 8;
        end
        tick_en = 1'b0;
    endtask

    task automatic accept(input logic [1:0] sel);
        l1a = 1'b1; l1a_sel = sel;
        @(negedge clk);
        l1a = 1'b0;
        if (b_full[sel]) begin
            m_ovf = 1'b1;
        end else begin
            m_cnt++;
            for (int k = 0; k < 8; k++) begin
                b_mask[sel][k] = h_mask[(h_wp + k) % 8];
                b_fit[sel][k]  = h_fit[(h_wp + k) % 8];
                b_dec[sel][k]  = h_dec[(h_wp + k) % 8];
            end
            b_tag[sel] = {sel, 14'(m_cnt)};
            b_full[sel] = 1'b1;
        end
    endtask

    // reads one buffer; gaps=1 inserts random idle cycles
    task automatic read_check(input logic [1:0] sel, input bit gaps);
        logic [15:0] e;
        string rq;
        rd_start = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_start = 1'b0;
        if (!b_full[sel]) begin
            for (int k = 0; k < 3; k++) begin
                rd_strobe = 1'b1;
                @(negedge clk);
                chk(!rd_valid, "R5 free buffer gives no word", 32'(rd_valid), 32'd0);
            end
            rd_strobe = 1'b0;
            return;
        end
        for (int i = 0; i < 282; i++) begin
            if (gaps && ($urandom() % 4 == 0)) begin
                rd_strobe = 1'b0;
                @(negedge clk);
                chk(!rd_valid, "R6 no strobe no word", 32'(rd_valid), 32'd0);
            end
            rd_strobe = 1'b1;
            @(negedge clk);
            e = exp_word(sel, i);
            rq = (i == 0) ? "R3 tag" : (i == 1) ? "R7 status" : (i < 82) ? "R8 mask word" : "R9 result word";
            chk(rd_valid, "R6 strobe gives word", 32'(rd_valid), 32'd1);
            chk(rd_data == e, rq, 32'(rd_data), 32'(e));
            chk(rd_last == (i == 281), "R10 last flag", 32'(rd_last), 32'(i == 281));
        end
        rd_strobe = 1'b0;
        b_full[sel] = 1'b0;
        @(negedge clk);
        chk(!rd_valid && !rd_last, "R10 session closed", {rd_valid, rd_last}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 8; k++) begin h_mask[k] = '0; h_fit[k] = '0; h_dec[k] = '0; end
        for (int b = 0; b < 4; b++) begin b_full[b] = 1'b0; b_tag[b] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_valid && !rd_last, "R1 reset outputs", {rd_valid, rd_last}, 32'd0);
        // R1/R5: nothing stored after reset
        read_check(2'd0, 1'b0);
        // R2: short history, older slots zero
        ticks(3);
        accept(2'd0);
        read_check(2'd0, 1'b0);
        // R10: drained buffer accepts again without overflow
        ticks(11);
        accept(2'd0);
        read_check(2'd0, 1'b1);
        // R4: refused accept leaves buffer 1 intact
        ticks(9);
        accept(2'd1);
        ticks(4);
        accept(2'd1);
        ticks(2);
        accept(2'd3);
        read_check(2'd1, 1'b0);
        read_check(2'd3, 1'b1);
        // random mix
        for (int it = 0; it < 14; it++) begin
            ticks($urandom() % 11);
            accept(2'($urandom()));
            if ($urandom() % 2 == 0) read_check(2'($urandom()), 1'b1);
        end
        for (int b = 0; b < 4; b++) read_check(2'(b), 1'b0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule